// File: doc/BRIEF.md
# Renaming Reorder Buffer Core

This block executes a stream of simple integer operations out of order and commits them in order. Each decoded operation is written into a circular reorder buffer at the tail. Its two source operands are resolved against a rename table that records, for every architectural register, whether a pending buffer entry will produce its next value and which entry that is. A source is then either ready, holding its value, or waiting on a tag.

A single execute port chooses the oldest entry whose operands are both ready. It computes the result with a small combinational ALU and broadcasts it, with the entry's tag, on a result bus. Waiting sources with a matching tag capture that value. The head entry retires once complete: its value goes into the architectural register file, and the rename mapping is dropped if it still names that entry. Fetch, decode, branches and memory operations are outside this block.

Top module: `rrob_core`

## Requirements
- R1: After reset the buffer is empty, `disp_ready_o` is 1, `ret_valid_o` is 0, and architectural register r holds the value r.
- R2: The 2-bit opcode selects the result modulo 2^W: 0 gives src1+src2, 1 gives src1-src2, 2 gives src1 XOR src2, and 3 gives src1+immediate.
- R3: A source whose register has no pending producer takes its value from the architectural register file when it is dispatched.
- R4: A source whose producer has already completed, or is broadcasting in the same cycle, copies that value at dispatch. Dependent operations issued back to back give the in-order result.
- R5: A waiting source captures the broadcast value when the tag on the result bus matches its own. Operations queued behind incomplete producers finish with the correct values once execution resumes.
- R6: Retirement is strictly in dispatch order, at most one per cycle, and only for a completed head entry. The retired sequence of (destination, value) pairs equals that of sequential execution.
- R7: While the buffer holds DEPTH entries, `disp_ready_o` is 0 and a dispatch request is ignored; the entry count never exceeds DEPTH.
- R8: While `exec_en_i` is 0 no entry completes, so an incomplete head is never retired.
- R9: Every register marked as renamed points at an occupied entry whose destination is that register.
- R10: For every occupied entry, its destination register is either not renamed or renamed to that entry or a younger one.
- R11: Retirement clears a register's mapping only if the mapping still names the retiring entry. With an empty buffer no register is renamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en_i | input | 1 | Allows the execute port to issue in this cycle |
| disp_req_i | input | 1 | A decoded operation is offered for dispatch |
| disp_op_i | input | 2 | Opcode (see R2) |
| disp_dst_i | input | $clog2(NREG) | Destination register |
| disp_src1_i | input | $clog2(NREG) | First source register |
| disp_src2_i | input | $clog2(NREG) | Second source register |
| disp_imm_i | input | W | Immediate operand for opcode 3 |
| disp_ready_o | output | 1 | Buffer has room; a request is taken at this edge |
| ret_valid_o | output | 1 | Head entry retires at the coming edge |
| ret_dst_o | output | $clog2(NREG) | Destination of the retiring entry |
| ret_data_o | output | W | Value written to the register file |

## Verification
The mapping invariants and the window checks take the inputs to be well formed and need no further assumptions. Register numbers must be below NREG, and the dispatch fields must be stable while `disp_req_i` is high. The bench drives only in-range register numbers and changes inputs only on the falling edge. It sweeps every opcode and source pair of the eight-register configuration. It also stalls the execute port to fill the buffer, and then toggles `exec_en_i` at random so that sources are resolved by all three paths: from the register file, from a completed entry, and from the result bus.

// File: rtl/rrob_pkg.sv
// Package: shared opcode encoding for the rename / reorder-buffer core.
// Assumes a 2-bit opcode field supplied by the decoder.
package rrob_pkg;
    localparam int OPW = 2;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_XOR  = 2'd2,
        OP_ADDI = 2'd3
    } op_e;
endpackage

// File: rtl/rrob_alu.sv
// Module: combinational integer unit used by the execute port.
// Assumes operands are already resolved; the result wraps modulo 2^W.
module rrob_alu #(
    parameter int W = 16
) (
    input  rrob_pkg::op_e  op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [W-1:0]   imm_i,
    output logic [W-1:0]   y_o
);
    // Select the operation named by the opcode.
    always_comb begin
        unique case (op_i)
            rrob_pkg::OP_ADD:  y_o = a_i + b_i;
            rrob_pkg::OP_SUB:  y_o = a_i - b_i;
            rrob_pkg::OP_XOR:  y_o = a_i ^ b_i;
            default:           y_o = a_i + imm_i;
        endcase
    end
endmodule

// File: rtl/rrob_issue_select.sv
// Module: oldest-first picker for the single execute port.
// Assumes entry flags are indexed by buffer slot and head marks the oldest slot.
module rrob_issue_select #(
    parameter int DEPTH = 4,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] valid_i,
    input  logic [DEPTH-1:0] done_i,
    input  logic [DEPTH-1:0] rdy1_i,
    input  logic [DEPTH-1:0] rdy2_i,
    input  logic [TW-1:0]    head_i,
    output logic             sel_v_o,
    output logic [TW-1:0]    sel_idx_o
);
    // Walk from head toward tail and take the first entry with both operands ready.
    always_comb begin
        sel_v_o   = 1'b0;
        sel_idx_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [TW-1:0] idx;
            idx = head_i + TW'(k);
            if (!sel_v_o && valid_i[idx] && !done_i[idx] && rdy1_i[idx] && rdy2_i[idx]) begin
                sel_v_o   = 1'b1;
                sel_idx_o = idx;
            end
        end
    end
endmodule

// File: rtl/rrob_rename_map.sv
// Module: per-register rename table (mapped flag plus producer tag).
// Assumes a set and a clear may hit the same register in one cycle; the set wins.
module rrob_rename_map #(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    localparam int RW   = $clog2(NREG),
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en_i,
    input  logic [RW-1:0]            set_reg_i,
    input  logic [TW-1:0]            set_tag_i,
    input  logic                     clr_en_i,
    input  logic [RW-1:0]            clr_reg_i,
    input  logic [TW-1:0]            clr_tag_i,
    output logic [NREG-1:0]          map_v_o,
    output logic [NREG-1:0][TW-1:0]  map_tag_o
);
    logic [NREG-1:0]         map_v_q;
    logic [NREG-1:0][TW-1:0] map_tag_q;

    // Update each register's mapping: clear on matching retirement, then apply dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_v_q   <= '0;
            map_tag_q <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (clr_en_i && clr_reg_i == RW'(r) && map_tag_q[r] == clr_tag_i)
                    map_v_q[r] <= 1'b0;
                if (set_en_i && set_reg_i == RW'(r)) begin
                    map_v_q[r]   <= 1'b1;
                    map_tag_q[r] <= set_tag_i;
                end
            end
        end
    end

    assign map_v_o   = map_v_q;
    assign map_tag_o = map_tag_q;

    AST_KEEP_FOREIGN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && map_v_q[clr_reg_i] && map_tag_q[clr_reg_i] != clr_tag_i)
        |=> map_v_q[$past(clr_reg_i)]); // R11
endmodule

// File: rtl/rrob_core.sv
// Module: top of the renaming reorder-buffer core (dispatch, execute, retire).
// Assumes DEPTH is a power of two of at least 2 and register numbers are below NREG.
module rrob_core #(
    parameter int NREG  = 8,
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int RW   = $clog2(NREG),
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exec_en_i,
    input  logic          disp_req_i,
    input  logic [1:0]    disp_op_i,
    input  logic [RW-1:0] disp_dst_i,
    input  logic [RW-1:0] disp_src1_i,
    input  logic [RW-1:0] disp_src2_i,
    input  logic [W-1:0]  disp_imm_i,
    output logic          disp_ready_o,
    output logic          ret_valid_o,
    output logic [RW-1:0] ret_dst_o,
    output logic [W-1:0]  ret_data_o
);
    typedef struct packed {
        logic          rdy;
        logic [W-1:0]  val;
        logic [TW-1:0] tag;
    } src_t;

    // Pointers carry one wrap bit so full and empty are distinguishable.
    logic [TW:0]   head_q, tail_q, count_w;
    logic [TW-1:0] head_idx, tail_idx;
    logic          full_w, disp_fire, ret_fire;

    // Entry storage, one slot per buffer position.
    logic [DEPTH-1:0] valid_q, done_q, r1_q, r2_q;
    logic [W-1:0]     res_q [DEPTH];
    logic [W-1:0]     v1_q  [DEPTH];
    logic [W-1:0]     v2_q  [DEPTH];
    logic [TW-1:0]    t1_q  [DEPTH];
    logic [TW-1:0]    t2_q  [DEPTH];
    logic [RW-1:0]    dst_q [DEPTH];
    logic [1:0]       op_q  [DEPTH];
    logic [W-1:0]     imm_q [DEPTH];

    logic [W-1:0]     rf_q  [NREG];

    logic [NREG-1:0]         map_v;
    logic [NREG-1:0][TW-1:0] map_tag;

    logic          sel_v, bc_v;
    logic [TW-1:0] sel_idx, bc_tag;
    logic [W-1:0]  bc_val;
    src_t          s1_w, s2_w;

    assign head_idx     = head_q[TW-1:0];
    assign tail_idx     = tail_q[TW-1:0];
    assign count_w      = tail_q - head_q;
    assign full_w       = (count_w == (TW+1)'(DEPTH));
    assign disp_fire    = disp_req_i && !full_w;
    assign ret_fire     = valid_q[head_idx] && done_q[head_idx];
    assign disp_ready_o = !full_w;
    assign ret_valid_o  = ret_fire;
    assign ret_dst_o    = dst_q[head_idx];
    assign ret_data_o   = res_q[head_idx];

    rrob_rename_map #(.NREG(NREG), .DEPTH(DEPTH)) map_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en_i  (disp_fire),
        .set_reg_i (disp_dst_i),
        .set_tag_i (tail_idx),
        .clr_en_i  (ret_fire),
        .clr_reg_i (dst_q[head_idx]),
        .clr_tag_i (head_idx),
        .map_v_o   (map_v),
        .map_tag_o (map_tag)
    );

    rrob_issue_select #(.DEPTH(DEPTH)) sel_i (
        .valid_i   (valid_q),
        .done_i    (done_q),
        .rdy1_i    (r1_q),
        .rdy2_i    (r2_q),
        .head_i    (head_idx),
        .sel_v_o   (sel_v),
        .sel_idx_o (sel_idx)
    );

    assign bc_v   = exec_en_i && sel_v;
    assign bc_tag = sel_idx;

    rrob_alu #(.W(W)) alu_i (
        .op_i  (rrob_pkg::op_e'(op_q[sel_idx])),
        .a_i   (v1_q[sel_idx]),
        .b_i   (v2_q[sel_idx]),
        .imm_i (imm_q[sel_idx]),
        .y_o   (bc_val)
    );

    // Resolve one source: register file, completed producer, live broadcast, or wait on tag.
    function automatic src_t resolve(input logic [RW-1:0] r);
        src_t s;
        s.rdy = 1'b1;
        s.tag = map_tag[r];
        s.val = rf_q[r];
        if (map_v[r]) begin
            if (done_q[map_tag[r]])
                s.val = res_q[map_tag[r]];
            else if (bc_v && bc_tag == map_tag[r])
                s.val = bc_val;
            else begin
                s.rdy = 1'b0;
                s.val = '0;
            end
        end
        return s;
    endfunction

    // Resolve both dispatch sources against the current mapping.
    always_comb begin
        s1_w = resolve(disp_src1_i);
        s2_w = resolve(disp_src2_i);
    end

    // Advance head on retirement and tail on dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (ret_fire)  head_q <= head_q + 1'b1;
            if (disp_fire) tail_q <= tail_q + 1'b1;
        end
    end

    // Write the retiring result into the architectural register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf_q[i] <= W'(i);
        end else if (ret_fire) begin
            rf_q[dst_q[head_idx]] <= res_q[head_idx];
        end
    end

    // Per-entry update: retire, complete, wake waiting sources, and fill on dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            done_q  <= '0;
            r1_q    <= '0;
            r2_q    <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                res_q[i] <= '0;  v1_q[i] <= '0;  v2_q[i] <= '0;
                t1_q[i]  <= '0;  t2_q[i] <= '0;  dst_q[i] <= '0;
                op_q[i]  <= '0;  imm_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ret_fire && head_idx == TW'(i))
                    valid_q[i] <= 1'b0;
                if (bc_v && bc_tag == TW'(i)) begin
                    done_q[i] <= 1'b1;
                    res_q[i]  <= bc_val;
                end
                if (valid_q[i] && !r1_q[i] && bc_v && t1_q[i] == bc_tag) begin
                    r1_q[i] <= 1'b1;
                    v1_q[i] <= bc_val;
                end
                if (valid_q[i] && !r2_q[i] && bc_v && t2_q[i] == bc_tag) begin
                    r2_q[i] <= 1'b1;
                    v2_q[i] <= bc_val;
                end
                if (disp_fire && tail_idx == TW'(i)) begin
                    valid_q[i] <= 1'b1;
                    done_q[i]  <= 1'b0;
                    r1_q[i]    <= s1_w.rdy;
                    v1_q[i]    <= s1_w.val;
                    t1_q[i]    <= s1_w.tag;
                    r2_q[i]    <= s2_w.rdy;
                    v2_q[i]    <= s2_w.val;
                    t2_q[i]    <= s2_w.tag;
                    dst_q[i]   <= disp_dst_i;
                    op_q[i]    <= disp_op_i;
                    imm_q[i]   <= disp_imm_i;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    logic [TW:0] done_cnt;
    assign done_cnt = (TW+1)'($countones(valid_q & done_q));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_w <= (TW+1)'(DEPTH)); // R7
    AST_FULL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        full_w |=> tail_q == $past(tail_q)); // R7
    AST_HOLD_NO_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en_i |=> done_cnt <= $past(done_cnt)); // R8
    AST_EMPTY_NO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        count_w == '0 |-> map_v == '0); // R11

    for (genvar r = 0; r < NREG; r++) begin : g_reg_chk
        AST_MAP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            map_v[r] |-> (valid_q[map_tag[r]] && dst_q[map_tag[r]] == RW'(r))); // R9
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent_chk
        logic [TW-1:0] age_e, age_m;
        assign age_e = TW'(e) - head_idx;
        assign age_m = map_tag[dst_q[e]] - head_idx;
        AST_VALID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[e] == ({1'b0, age_e} < count_w)); // R6
        AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            valid_q[e] |-> (!map_v[dst_q[e]] || age_m >= age_e)); // R10
    end
endmodule

// File: tb/rrob_core_tb_top.sv
// Bench: sweeps opcodes and source pairs, fills the buffer with execution held,
// then runs random streams; every retirement is compared with a sequential model.
module rrob_core_tb_top;
    localparam int NREG  = 8;
    localparam int DEPTH = 4;
    localparam int W     = 16;
    localparam int RW    = $clog2(NREG);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec_en_i = 1'b0;
    logic          disp_req_i = 1'b0;
    logic [1:0]    disp_op_i = '0;
    logic [RW-1:0] disp_dst_i = '0, disp_src1_i = '0, disp_src2_i = '0;
    logic [W-1:0]  disp_imm_i = '0;
    logic          disp_ready_o, ret_valid_o;
    logic [RW-1:0] ret_dst_o;
    logic [W-1:0]  ret_data_o;

    int checks = 0;
    int errors = 0;
    bit rand_exec = 1'b0;
    bit finished = 1'b0;

    logic [W-1:0] ref_rf [NREG];
    int           exp_dst [$];
    logic [W-1:0] exp_val [$];
    string        exp_req [$];

    always #2.5 clk = ~clk;

    rrob_core #(.NREG(NREG), .DEPTH(DEPTH), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .exec_en_i(exec_en_i),
        .disp_req_i(disp_req_i), .disp_op_i(disp_op_i), .disp_dst_i(disp_dst_i),
        .disp_src1_i(disp_src1_i), .disp_src2_i(disp_src2_i), .disp_imm_i(disp_imm_i),
        .disp_ready_o(disp_ready_o), .ret_valid_o(ret_valid_o),
        .ret_dst_o(ret_dst_o), .ret_data_o(ret_data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_alu(input int op, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic [W-1:0] imm);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a ^ b;
            default: return a + imm;
        endcase
    endfunction

    // Compare every retirement with the head of the sequential model's queue (R6).
    always @(negedge clk) begin
        if (rst_n && ret_valid_o) begin
            if (exp_dst.size() == 0) begin
                chk(1'b0, "R6 unexpected retirement", int'(ret_dst_o), -1);
            end else begin
                string q;
                q = exp_req.pop_front();
                chk(int'(ret_dst_o) == exp_dst[0], {q, " dst"}, int'(ret_dst_o), exp_dst[0]);
                chk(ret_data_o == exp_val[0], {q, " data"}, int'(ret_data_o), int'(exp_val[0]));
                void'(exp_dst.pop_front());
                void'(exp_val.pop_front());
            end
        end
    end

    task automatic rand_exec_step();
        if (rand_exec) exec_en_i = ($urandom_range(0, 3) != 0);
    endtask

    // Offer one operation, wait until it is taken, and record the sequential result.
    task automatic send(input int op, input int dst, input int s1, input int s2,
                        input logic [W-1:0] imm, input string req);
        logic [W-1:0] res;
        disp_req_i  = 1'b1;
        disp_op_i   = 2'(op);
        disp_dst_i  = RW'(dst);
        disp_src1_i = RW'(s1);
        disp_src2_i = RW'(s2);
        disp_imm_i  = imm;
        while (!disp_ready_o) begin
            @(negedge clk);
            rand_exec_step();
        end
        res = ref_alu(op, ref_rf[s1], ref_rf[s2], imm);
        ref_rf[dst] = res;
        exp_dst.push_back(dst);
        exp_val.push_back(res);
        exp_req.push_back(req);
        @(negedge clk);
        rand_exec_step();
        disp_req_i = 1'b0;
    endtask

    task automatic drain();
        exec_en_i = 1'b1;
        for (int i = 0; i < 400 && exp_dst.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_dst.size() == 0, "R6 drained", exp_dst.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) ref_rf[i] = W'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        chk(disp_ready_o == 1'b1, "R1 ready after reset", int'(disp_ready_o), 1);
        chk(ret_valid_o == 1'b0, "R1 no retire after reset", int'(ret_valid_o), 0);

        // R1 / R3: reset register values read through unmapped sources.
        exec_en_i = 1'b1;
        for (int r = 0; r < NREG; r++) send(3, r, r, 0, '0, "R1 R3 reset value");
        drain();

        // R2: all opcodes over all source pairs.
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < NREG; a++)
                for (int b = 0; b < NREG; b++)
                    send(op, (a + b + op) % NREG, a, b, W'(op * 37 + a * 5 + 1), "R2 opcode sweep");
        drain();

        // R4: back-to-back dependent chain through bypass and completed producers.
        for (int i = 0; i < 20; i++) send(0, 1, 1, 1, '0, "R4 chain");
        for (int i = 0; i < 12; i++) send(3, 2, (i % 2 == 0) ? 1 : 2, 2, W'(i + 3), "R4 mixed chain");
        drain();

        // R7 / R8: hold execution, fill the buffer, try one extra request.
        exec_en_i = 1'b0;
        for (int i = 0; i < DEPTH; i++) send(0, 3, 3, (i == 0) ? 4 : 3, '0, "R5 wakeup chain");
        chk(disp_ready_o == 1'b0, "R7 full stall", int'(disp_ready_o), 0);
        disp_req_i = 1'b1; disp_op_i = 2'd3; disp_dst_i = RW'(5);
        disp_src1_i = RW'(5); disp_src2_i = RW'(5); disp_imm_i = W'(99);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(ret_valid_o == 1'b0, "R8 no retire while held", int'(ret_valid_o), 0);
            chk(disp_ready_o == 1'b0, "R7 still full", int'(disp_ready_o), 0);
        end
        disp_req_i = 1'b0;
        drain();
        // R7: the ignored request must not have written r5; read it back.
        send(3, 6, 5, 5, '0, "R7 ignored request left r5");
        drain();

        // R3 / R5 / R6: random streams with the execute port toggled.
        rand_exec = 1'b1;
        for (int n = 0; n < 2000; n++) begin
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk);
                rand_exec_step();
            end
            send($urandom_range(0, 3), $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
                 $urandom_range(0, NREG - 1), W'($urandom), "R6 random stream");
        end
        rand_exec = 1'b0;
        drain();

        // R3 / R11: after draining every register reads the sequential value.
        for (int r = 0; r < NREG; r++) send(3, r, r, r, '0, "R3 R11 final register");
        drain();
        chk(disp_ready_o == 1'b1, "R6 ready when empty", int'(disp_ready_o), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule